// File: doc/BRIEF.md
# Fast Interrupt Pending Controller

This block sits between a group of peripheral interrupt request lines and a processor core. It turns each rising edge on a request line into a sticky pending flag. That flag holds until software clears it. The peripheral that raised the request has no way to clear it. Software reads and clears the flags through one read/write interrupt-pending register on a simple CSR access port. The fast channels occupy an upper field of that register.

The controller combines the pending flags with the matching bits of the machine interrupt-enable register and with a global enable. When the result is non-zero, it raises a request to the core and gives the index of the lowest-numbered pending, enabled channel. Trap entry, vectoring and the other standard interrupt sources live elsewhere.

Top module: `fast_irq_pend_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears every pending flag, every stored copy of the request lines, `csr_rdata_o`, `irq_o` and `irq_id_o`. A request line already high when reset is released counts as a new rising edge on the first clock after release.
- R2: A 0-to-1 change of `req_i[n]` between two clock edges sets pending flag n at the edge where the line is first seen high. Flag n appears at register bit BASE+n (bit 16+n by default).
- R3: A request line that stays high produces no further event. Once software clears the flag, it stays clear while the line remains high.
- R4: A pending flag stays set after its request line returns low. It stays set until software clears it.
- R5: A CSR write (`csr_sel_i` and `csr_wr_i` high) with a 1 at bit BASE+n of `csr_wdata_i` clears flag n. A 0 at that bit leaves flag n as it was.
- R6: Register bits outside BASE..BASE+NUM_CH-1 always read as 0. Writes to those bits change nothing. Enable bits outside that field have no effect on `irq_o`.
- R7: If a rising edge on line n and a write-one-to-clear of flag n happen in the same cycle, flag n ends up set.
- R8: `irq_o` is high in a cycle only if, at the previous clock edge, some flag n was set, enable bit BASE+n of `ie_i` was 1, and `gie_i` was 1.
- R9: When several enabled flags are pending, `irq_id_o` gives the lowest channel index among them. It is 0 when `irq_o` is low.
- R10: With `gie_i` low, rising edges are still captured as pending flags.
- R11: A CSR read (`csr_sel_i` and `csr_rd_i` high) returns the register on `csr_rdata_o` one cycle later. The value is the one held before any write in the same cycle. With no read, `csr_rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_CH (16) | Raw fast interrupt request lines, one per channel |
| csr_sel_i | input | 1 | CSR address matches the interrupt-pending register |
| csr_rd_i | input | 1 | CSR read strobe |
| csr_wr_i | input | 1 | CSR write strobe (write-one-to-clear) |
| csr_wdata_i | input | XLEN (32) | CSR write data |
| ie_i | input | XLEN (32) | Machine interrupt-enable register contents |
| gie_i | input | 1 | Global interrupt enable |
| csr_rdata_o | output | XLEN (32) | Registered read data of the pending register |
| irq_o | output | 1 | Registered request to the core |
| irq_id_o | output | IDW (4) | Registered index of the winning channel |

## Verification
The bench builds the block with its default values: 16 channels in field 16..31 of a 32-bit register. With these values the read data shows both the empty low half and the full channel field. The lowest and highest channel indices can then both win arbitration. A table walks sequences of rising edges, held and dropped lines, clears, enables and global gating. Directed tests cover writes to the unused bits and reset while a line is held high. The same-cycle clear and rising edge is driven on one channel.

// File: rtl/firq_pkg.sv
package firq_pkg;
  localparam int DEF_NUM_CH = 16;
  localparam int DEF_BASE   = 16;
  localparam int DEF_XLEN   = 32;

  typedef struct packed {
    logic sel;
    logic rd;
    logic wr;
  } csr_acc_t;
endpackage

// File: rtl/firq_edge_capture.sv
module firq_edge_capture #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_i,
  output logic [NUM_CH-1:0] hist_o,
  output logic [NUM_CH-1:0] rise_o
);
  logic [NUM_CH-1:0] hist_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) hist_q[g] <= 1'b0;
      else     hist_q[g] <= req_i[g];
    end
    assign rise_o[g] = req_i[g] & ~hist_q[g];
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/firq_pend_bank.sv
module firq_pend_bank #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] rise_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] pend_o
);
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] pend_d;

  // a new event wins over a clear in the same cycle
  always_comb pend_d = (pend_q & ~clr_i) | rise_i;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/firq_prio_pick.sv
module firq_prio_pick #(
  parameter int NUM_CH = 16,
  parameter int IDW    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic              gie_i,
  output logic              irq_o,
  output logic [IDW-1:0]    id_o
);
  logic [NUM_CH-1:0] live;
  logic              any_d;
  logic [IDW-1:0]    id_d;

  always_comb begin
    live  = pend_i & en_i & {NUM_CH{gie_i}};
    any_d = |live;
    id_d  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (live[i]) id_d = IDW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      id_o  <= '0;
    end else begin
      irq_o <= any_d;
      id_o  <= id_d;
    end
  end
endmodule

// File: rtl/fast_irq_pend_ctrl.sv
module fast_irq_pend_ctrl
  import firq_pkg::*;
#(
  parameter int NUM_CH = DEF_NUM_CH,
  parameter int BASE   = DEF_BASE,
  parameter int XLEN   = DEF_XLEN,
  localparam int IDW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              csr_sel_i,
  input  logic              csr_rd_i,
  input  logic              csr_wr_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  logic [XLEN-1:0]   ie_i,
  input  logic              gie_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              irq_o,
  output logic [IDW-1:0]    irq_id_o
);
  localparam logic [XLEN-1:0] FIELD_MASK = XLEN'({NUM_CH{1'b1}}) << BASE;

  csr_acc_t          acc;
  logic [NUM_CH-1:0] req_hist;
  logic [NUM_CH-1:0] rise_vec;
  logic [NUM_CH-1:0] clr_vec;
  logic [NUM_CH-1:0] pend_vec;
  logic [NUM_CH-1:0] en_vec;
  logic [XLEN-1:0]   rdata_q;
  logic              unused_bits;

  assign acc     = '{sel: csr_sel_i, rd: csr_rd_i, wr: csr_wr_i};
  assign clr_vec = (acc.sel && acc.wr) ? csr_wdata_i[BASE +: NUM_CH] : '0;
  assign en_vec  = ie_i[BASE +: NUM_CH];
  assign unused_bits = ^((ie_i | csr_wdata_i) & ~FIELD_MASK);

  firq_edge_capture #(.NUM_CH(NUM_CH)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .hist_o (req_hist),
    .rise_o (rise_vec)
  );

  firq_pend_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .rise_i (rise_vec),
    .clr_i  (clr_vec),
    .pend_o (pend_vec)
  );

  firq_prio_pick #(.NUM_CH(NUM_CH), .IDW(IDW)) u_pick (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend_vec),
    .en_i   (en_vec),
    .gie_i  (gie_i),
    .irq_o  (irq_o),
    .id_o   (irq_id_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                  rdata_q <= '0;
    else if (acc.sel && acc.rd) rdata_q <= XLEN'(pend_vec) << BASE;
    else                      rdata_q <= '0;
  end

  assign csr_rdata_o = rdata_q;
endmodule

// File: rtl/firq_pend_chk.sv
module firq_pend_chk #(
  parameter int NUM_CH = 16,
  parameter int BASE   = 16,
  parameter int XLEN   = 32,
  parameter int IDW    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] req_i,
  input logic              csr_sel_i,
  input logic              csr_wr_i,
  input logic [XLEN-1:0]   csr_wdata_i,
  input logic [XLEN-1:0]   ie_i,
  input logic              gie_i,
  input logic [NUM_CH-1:0] req_hist,
  input logic [NUM_CH-1:0] pend_vec,
  input logic [XLEN-1:0]   csr_rdata_o,
  input logic              irq_o,
  input logic [IDW-1:0]    irq_id_o
);
  localparam logic [XLEN-1:0] FIELD_MASK = XLEN'({NUM_CH{1'b1}}) << BASE;

  logic [NUM_CH-1:0] edge_now;
  logic [NUM_CH-1:0] wipe_now;
  logic [NUM_CH-1:0] live_prev;

  assign edge_now = req_i & ~req_hist;
  assign wipe_now = (csr_sel_i && csr_wr_i) ? csr_wdata_i[BASE +: NUM_CH] : '0;

  always_ff @(posedge clk) live_prev <= pend_vec & ie_i[BASE +: NUM_CH] & {NUM_CH{gie_i}};

  // R2 R7
  rise_captured_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_now != '0) |=> ((pend_vec & $past(edge_now)) == $past(edge_now)));

  // R4
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_vec & ~wipe_now) != '0 |=>
      ((pend_vec & $past(pend_vec & ~wipe_now)) == $past(pend_vec & ~wipe_now)));

  // R5
  w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (wipe_now & ~edge_now) != '0 |=> ((pend_vec & $past(wipe_now & ~edge_now)) == '0));

  // R6
  outside_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_rdata_o & ~FIELD_MASK) == '0);

  // R8 R9
  irq_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> live_prev[irq_id_o]);

  // R9
  id_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> (irq_id_o == '0));
endmodule

bind fast_irq_pend_ctrl firq_pend_chk #(
  .NUM_CH(NUM_CH), .BASE(BASE), .XLEN(XLEN), .IDW(IDW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_i       (req_i),
  .csr_sel_i   (csr_sel_i),
  .csr_wr_i    (csr_wr_i),
  .csr_wdata_i (csr_wdata_i),
  .ie_i        (ie_i),
  .gie_i       (gie_i),
  .req_hist    (req_hist),
  .pend_vec    (pend_vec),
  .csr_rdata_o (csr_rdata_o),
  .irq_o       (irq_o),
  .irq_id_o    (irq_id_o)
);

// File: tb/fast_irq_pend_ctrl_tb.sv
module fast_irq_pend_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] req;
  logic        sel, rd, wr;
  logic [31:0] wdata, ie;
  logic        gie;
  logic [31:0] rdata;
  logic        irq;
  logic [3:0]  id;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  fast_irq_pend_ctrl u_dut (
    .clk(clk), .rst(rst), .req_i(req), .csr_sel_i(sel), .csr_rd_i(rd),
    .csr_wr_i(wr), .csr_wdata_i(wdata), .ie_i(ie), .gie_i(gie),
    .csr_rdata_o(rdata), .irq_o(irq), .irq_id_o(id)
  );

  // fields: req, wr, clear bits (reg bits 31:16), enable (reg bits 31:16), gie, expected pending
  localparam int NV = 16;
  localparam logic [65:0] VECS [NV] = '{
    {16'h0001, 1'b0, 16'h0000, 16'hFFFF, 1'b1, 16'h0001}, // R2 rise ch0
    {16'h0001, 1'b1, 16'h0001, 16'hFFFF, 1'b1, 16'h0000}, // R5 clear while held
    {16'h0001, 1'b0, 16'h0000, 16'hFFFF, 1'b1, 16'h0000}, // R3 held high, no re-set
    {16'h0000, 1'b0, 16'h0000, 16'hFFFF, 1'b1, 16'h0000},
    {16'h8004, 1'b0, 16'h0000, 16'hFFFF, 1'b1, 16'h8004}, // R9 ch2 beats ch15
    {16'h0000, 1'b0, 16'h0000, 16'hFFFF, 1'b1, 16'h8004}, // R4 lines dropped
    {16'h0000, 1'b1, 16'h0000, 16'hFFFF, 1'b1, 16'h8004}, // R5 zeros keep
    {16'h0000, 1'b1, 16'h0004, 16'hFFFF, 1'b1, 16'h8000}, // R9 ch15 alone
    {16'h0000, 1'b0, 16'h0000, 16'h7FFF, 1'b1, 16'h8000}, // R8 disabled
    {16'h0010, 1'b0, 16'h0000, 16'hFFFF, 1'b0, 16'h8010}, // R10 gie low
    {16'h0010, 1'b1, 16'h8000, 16'hFFFF, 1'b1, 16'h0010},
    {16'h0000, 1'b1, 16'h0010, 16'hFFFF, 1'b1, 16'h0000},
    {16'h0020, 1'b0, 16'h0000, 16'hFFFF, 1'b1, 16'h0020},
    {16'h0000, 1'b0, 16'h0000, 16'hFFFF, 1'b1, 16'h0020},
    {16'h0020, 1'b1, 16'h0020, 16'hFFFF, 1'b1, 16'h0020}, // R7 rise and clear together
    {16'h0000, 1'b1, 16'h0020, 16'hFFFF, 1'b1, 16'h0000}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] lowest(input logic [15:0] v);
    logic [3:0] r = 4'd0;
    for (int i = 15; i >= 0; i--) if (v[i]) r = 4'(i);
    return r;
  endfunction

  task automatic read_back();
    sel = 1'b1; rd = 1'b1; wr = 1'b0;
    tick();
    rd = 1'b0; sel = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] live;
    rst = 1'b1; req = '0; sel = 1'b0; rd = 1'b0; wr = 1'b0;
    wdata = '0; ie = '0; gie = 1'b0;
    repeat (3) tick();
    check("R1 irq after reset", 32'(irq), 32'd0);
    check("R1 id after reset", 32'(id), 32'd0);
    check("R1 rdata during reset", rdata, 32'd0);
    rst = 1'b0;
    read_back();
    check("R1 pending after reset", rdata, 32'd0);
    tick();
    check("R11 rdata idle without read", rdata, 32'd0);

    for (int k = 0; k < NV; k++) begin
      logic [65:0] v = VECS[k];
      req = v[65:50]; wr = v[49]; sel = v[49]; wdata = {v[48:33], 16'h0000};
      ie = {v[32:17], 16'h0000}; gie = v[16];
      tick();
      read_back();
      live = v[15:0] & v[32:17] & {16{v[16]}};
      check($sformatf("R2/R4/R5/R7/R11 pend vec %0d", k), rdata, {v[15:0], 16'h0000});
      check($sformatf("R8/R10 irq vec %0d", k), 32'(irq), 32'(|live));
      check($sformatf("R9 id vec %0d", k), 32'(id), 32'(lowest(live)));
    end

    // R6: low field writes and enables have no effect
    req = 16'h0001; tick();
    sel = 1'b1; wr = 1'b1; wdata = 32'h0000_FFFF; tick();
    wr = 1'b0; sel = 1'b0;
    read_back();
    check("R6 low bits ignored on write", rdata, 32'h0001_0000);
    ie = 32'h0000_FFFF; gie = 1'b1; tick(); tick();
    check("R6 low enable bits ignored", 32'(irq), 32'd0);
    ie = 32'h0001_0000; tick(); tick();
    check("R8 enabled ch0 raises irq", 32'(irq), 32'd1);

    // R1: reset mid-run with line held, then release counts as rise
    rst = 1'b1; tick();
    check("R1 irq cleared by reset", 32'(irq), 32'd0);
    check("R1 rdata cleared by reset", rdata, 32'd0);
    rst = 1'b0; tick();
    read_back();
    check("R1 held line after reset captured", rdata, 32'h0001_0000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule